// File: doc/BRIEF.md
# USB Host Interrupt Enable Set/Clear Controller

This block sits between the event sources of a USB host controller and a downstream interrupt controller. It keeps seven per-source enable bits and one master enable. Software turns enables on by writing ones to a set register and turns them off by writing ones to a separate clear register, so no read-modify-write sequence is ever needed and concurrent agents cannot undo each other's changes.

Raw event pulses from the host logic latch into sticky status bits, which software acknowledges by writing ones to the status register. A single registered interrupt request is raised whenever the master enable is on and at least one latched source also has its own enable on.

The register port is a flat word-indexed bus: address, write strobe, write data, and combinational read data for the addressed word.

Top module: `usb_irq_enable_ctl`

## Requirements
- R1: After reset every source enable, the master enable and every status bit are 0, and irq_o is 0.
- R2: A write to address 1 (the set register) sets bit 31 (master) and each of bits 6..0 (source enables) where the write data holds a 1; bits written with 0 keep their value.
- R3: A write to address 2 (the clear register) clears bit 31 and each of bits 6..0 where the write data holds a 1; bits written with 0 keep their value.
- R4: Reading address 1 or address 2 returns the enable state: master in bit 31, source enables in bits 6..0, and 0 in bits 30..7; bit 30 (ownership change) is read-only and writing it has no effect.
- R5: A 1 on evt_raw[i] at a clock edge sets status bit i (positions 6 root hub change, 5 frame overflow, 4 unrecoverable error, 3 resume, 2 start of frame, 1 done head written, 0 scheduling overrun); reading address 0 returns the status in bits 6..0 and 0 above.
- R6: Writing a 1 to bit i at address 0 clears status bit i; if evt_raw[i] is 1 in that same cycle the bit stays set.
- R7: While the master enable is 0, irq_o is 0 on the following cycle, whatever the source enables and status.
- R8: irq_o equals, one clock later, the master enable ANDed with the OR over all sources of status AND source enable.
- R9: Address 3 (unmapped) reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Word index of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_raw | input | 7 | Raw event pulses from the host logic |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that every write is a single-cycle strobe whose address and data are stable at the sampling edge, and that evt_raw is synchronous to clk. They also assume nothing about event timing, so collisions of events with status-clear writes are legal and checked. The stimulus drives address, strobe, data and events only on the falling edge, chooses addresses across all four values including the unmapped one, and mixes random data with directed writes that hit bit 30 and the reserved bits.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int NSRC    = 7;
  localparam int DATA_W  = 32;
  localparam int MIE_POS = 31;
  localparam int OC_POS  = 30;

  // Interrupt request from latched status, source enables and master.
  function automatic logic irq_next(input logic [NSRC-1:0] st,
                                    input logic [NSRC-1:0] en,
                                    input logic            mie);
    return mie & (|(st & en));
  endfunction

  // Enable register image as seen on the bus.
  function automatic logic [DATA_W-1:0] pack_enable(input logic mie,
                                                    input logic [NSRC-1:0] en);
    logic [DATA_W-1:0] w;
    w = '0;
    w[MIE_POS]    = mie;
    w[NSRC-1:0]   = en;
    return w;
  endfunction

  // Status register image as seen on the bus.
  function automatic logic [DATA_W-1:0] pack_status(input logic [NSRC-1:0] st);
    logic [DATA_W-1:0] w;
    w = '0;
    w[NSRC-1:0] = st;
    return w;
  endfunction
endpackage

// File: rtl/usb_irq_en_bank.sv
module usb_irq_en_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_mask,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] en_q
);
  // One flop per enable; a clear request wins over a set request.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           en_q[i] <= 1'b0;
      else if (clr_mask[i]) en_q[i] <= 1'b0;
      else if (set_mask[i]) en_q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/usb_irq_status_bank.sv
module usb_irq_status_bank #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt,
  input  logic [WIDTH-1:0] ack_mask,
  output logic [WIDTH-1:0] st_q
);
  // Sticky latch; a new event wins over an acknowledge so nothing is lost.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           st_q[i] <= 1'b0;
      else if (evt[i])      st_q[i] <= 1'b1;
      else if (ack_mask[i]) st_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_irq_combine.sv
module usb_irq_combine
  import usb_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] st,
  input  logic [NSRC-1:0] en,
  input  logic            mie,
  output logic            irq_q
);
  logic irq_d;
  assign irq_d = irq_next(st, en, mie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/usb_irq_enable_ctl.sv
module usb_irq_enable_ctl
  import usb_irq_pkg::*;
#(
  parameter int ADDR_W       = 2,
  parameter int ADDR_STATUS  = 0,
  parameter int ADDR_SET     = 1,
  parameter int ADDR_CLEAR   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]   evt_raw,
  output logic              irq_o
);
  localparam int EN_W = NSRC + 1;   // source enables plus master

  // Decoded bus events, named for the checker.
  logic hit_status, hit_set, hit_clear;
  logic wr_status, wr_set, wr_clear;
  assign hit_status = (reg_addr == ADDR_W'(ADDR_STATUS));
  assign hit_set    = (reg_addr == ADDR_W'(ADDR_SET));
  assign hit_clear  = (reg_addr == ADDR_W'(ADDR_CLEAR));
  assign wr_status  = reg_wr & hit_status;
  assign wr_set     = reg_wr & hit_set;
  assign wr_clear   = reg_wr & hit_clear;

  // Write data bits that map onto enables: master on top, sources below.
  logic [EN_W-1:0] wbits;
  assign wbits = {reg_wdata[MIE_POS], reg_wdata[NSRC-1:0]};

  logic [EN_W-1:0] set_mask, clr_mask;
  assign set_mask = wr_set   ? wbits : '0;
  assign clr_mask = wr_clear ? wbits : '0;

  logic [NSRC-1:0] ack_mask;
  assign ack_mask = wr_status ? reg_wdata[NSRC-1:0] : '0;

  // Bits of the write data that have no storage behind them.
  logic unused_wbits;
  assign unused_wbits = ^reg_wdata[OC_POS:NSRC];

  logic [EN_W-1:0] en_all;
  logic [NSRC-1:0] src_en;
  logic            mie_q;
  logic [NSRC-1:0] st_q;

  usb_irq_en_bank #(.WIDTH(EN_W)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .en_q     (en_all)
  );

  assign src_en = en_all[NSRC-1:0];
  assign mie_q  = en_all[EN_W-1];

  usb_irq_status_bank #(.WIDTH(NSRC)) u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_raw),
    .ack_mask (ack_mask),
    .st_q     (st_q)
  );

  usb_irq_combine u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .st    (st_q),
    .en    (src_en),
    .mie   (mie_q),
    .irq_q (irq_o)
  );

  // Read mux; the ownership bit and the reserved gap are constant zero.
  always_comb begin
    if (hit_status)              reg_rdata = pack_status(st_q);
    else if (hit_set | hit_clear) reg_rdata = pack_enable(mie_q, src_en);
    else                         reg_rdata = '0;
  end
endmodule

// File: rtl/usb_irq_enable_ctl_chk.sv
module usb_irq_enable_ctl_chk
  import usb_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_set,
  input logic              wr_clear,
  input logic              wr_status,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NSRC-1:0]   evt_raw,
  input logic [NSRC-1:0]   src_en,
  input logic              mie_q,
  input logic [NSRC-1:0]   st_q,
  input logic              irq_o
);
  AST_SET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((src_en & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0])) && ($past(reg_wdata[MIE_POS]) -> mie_q)); // R2

  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((src_en & $past(src_en)) == $past(src_en)) && ($past(mie_q) -> mie_q)); // R2

  AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear |=> ((src_en & $past(reg_wdata[NSRC-1:0])) == '0) && ($past(reg_wdata[MIE_POS]) -> !mie_q)); // R3

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[OC_POS:NSRC] == '0); // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_status |=> ((st_q & $past(st_q)) == $past(st_q))); // R5

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_raw != '0) |=> ((st_q & $past(evt_raw)) == $past(evt_raw))); // R6

  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !mie_q |=> !irq_o); // R7

  AST_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & src_en) == '0) |=> !irq_o); // R8
endmodule

bind usb_irq_enable_ctl usb_irq_enable_ctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_set    (wr_set),
  .wr_clear  (wr_clear),
  .wr_status (wr_status),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .evt_raw   (evt_raw),
  .src_en    (src_en),
  .mie_q     (mie_q),
  .st_q      (st_q),
  .irq_o     (irq_o)
);

// File: tb/usb_irq_enable_ctl_bench.sv
module usb_irq_enable_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NS-1:0] evt_raw = '0;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Reference state
  logic [NS-1:0] m_en = '0;
  logic          m_mie = 1'b0;
  logic [NS-1:0] m_st = '0;
  logic          m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_enable_ctl u_usb_irq_enable_ctl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_raw(evt_raw), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:       return {25'd0, m_st};
      2'd1, 2'd2: return {m_mie, 24'd0, m_en};
      default:    return 32'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return m_mie && ((m_st & m_en) != '0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle; model updated at the edge, outputs checked 1 time unit after.
  task automatic cycle(input logic [1:0] a, input logic wr, input logic [31:0] d,
                       input logic [NS-1:0] ev, input string req);
    @(negedge clk);
    reg_addr = a; reg_wr = wr; reg_wdata = d; evt_raw = ev;
    @(posedge clk);
    m_irq = exp_irq();
    if (wr && a == 2'd1) begin m_en = m_en | d[NS-1:0]; m_mie = m_mie | d[31]; end
    if (wr && a == 2'd2) begin m_en = m_en & ~d[NS-1:0]; m_mie = m_mie & ~d[31]; end
    m_st = (m_st & ~((wr && a == 2'd0) ? d[NS-1:0] : '0)) | ev;
    #1;
    check({req, " irq R8"}, {31'd0, irq_o}, {31'd0, m_irq});
    check({req, " read"}, reg_rdata, exp_read(a));
    @(negedge clk);
    reg_wr = 1'b0; evt_raw = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq at reset", {31'd0, irq_o}, 32'd0);
    reg_addr = 2'd1; #1; check("R1 enables at reset", reg_rdata, 32'd0);
    reg_addr = 2'd0; #1; check("R1 status at reset", reg_rdata, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // Directed
    cycle(2'd1, 1, 32'h0000_0005, '0, "R2 set two sources");
    cycle(2'd1, 1, 32'h0000_0000, '0, "R2 zero write keeps");
    cycle(2'd1, 1, 32'h7FFF_FF80, '0, "R4 bit30 and reserved ignored");
    cycle(2'd2, 0, 32'h0, '0, "R4 read via clear address");
    cycle(2'd0, 0, 32'h0, 7'h01, "R5 event latches");
    cycle(2'd0, 0, 32'h0, '0, "R7 master off blocks");
    cycle(2'd0, 0, 32'h0, '0, "R7 master off blocks again");
    cycle(2'd1, 1, 32'h8000_0000, '0, "R2 master set");
    cycle(2'd1, 0, 32'h0, '0, "R8 irq follows one cycle later");
    cycle(2'd0, 1, 32'h0000_0001, 7'h01, "R6 event wins over ack");
    cycle(2'd0, 1, 32'h0000_0001, '0, "R6 ack clears");
    cycle(2'd3, 1, 32'hFFFF_FFFF, '0, "R9 unmapped write");
    cycle(2'd1, 0, 32'h0, 7'h7F, "R9 state unchanged");
    cycle(2'd2, 1, 32'h8000_0000, '0, "R3 clear master");
    cycle(2'd2, 1, 32'h0000_0004, '0, "R3 clear one source");
    cycle(2'd1, 0, 32'h0, '0, "R3 readback");

    // Constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 2000; i++) begin
      logic [1:0]  a;
      logic        w;
      logic [31:0] d;
      logic [NS-1:0] ev;
      a  = 2'($urandom_range(0, 3));
      w  = ($urandom_range(0, 2) != 0);
      d  = $urandom;
      if ($urandom_range(0, 3) == 0) d = d & 32'h8000_007F;
      ev = ($urandom_range(0, 3) == 0) ? NS'($urandom) : '0;
      cycle(a, w, d, ev, "R2 R3 R5 R6 R8 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule